// File: doc/BRIEF.md
# Escaped Byte-Stream Frame Decoder

This block sits behind a serial receiver and turns a raw byte stream into framed payload. Bytes enter on a valid/ready interface. A configurable separator byte splits the stream into frames, and two-byte escape sequences are turned back into the single bytes they stand for. Payload leaves on a second valid/ready interface, with start-of-frame and end-of-frame markers on the first and last byte of each frame. A frame also closes on its own once its payload grows past a programmable length limit.

An escape sequence is an escape-lead byte followed by a code byte. Up to `NRULE` rules map a code byte to a result byte, and each rule has its own enable. The usual setup is this: rule 0 maps 0xDC to the separator value, and rules 1 to 3 map 0xDD, 0xDE and 0xDF to 0xDB, 0x11 and 0x13. A malformed escape raises a one-cycle error pulse, and so does a separator that cuts an escape short. A separator that opens a frame raises a one-cycle start pulse.

Output holds back one payload byte. The decoder cannot know that a byte ends its frame until the next byte or separator arrives, so each byte is released only then. Back-pressure rules are as follows. An output beat stays unchanged while `out_ready` is low. `in_ready` is high only when the output register is empty or being taken in the same cycle, and no spilled byte is waiting. A beat and its flags update on the clock edge after the input byte that releases it is accepted.

Top module: `sfd_decoder`

## Requirements
- R1: After reset, `out_valid`, `err` and `rx_start` are 0 and `in_ready` is 1.
- R2: While `out_valid` is 1 and `out_ready` is 0, `out_data`, `out_sof` and `out_eof` hold their values and `in_ready` is 0.
- R3: With `sep_en`=1, an accepted byte equal to `sep_char` ends the open frame. The held last payload byte is emitted with `out_eof`=1. The first payload byte of each frame carries `out_sof`=1. A payload byte is emitted only after the following byte or separator is accepted.
- R4: Separators in a row produce no output beat. `rx_start` pulses for one cycle after each accepted separator that arrives with no frame open. A frame is open when payload has been collected since the last frame end, or when an escape is pending.
- R5: When at least one rule is enabled, `esc_char` followed by the code byte `rule_code[8i+7:8i]` of an enabled rule i produces the single payload byte `rule_val[8i+7:8i]`. When several enabled rules share a code, the lowest index wins.
- R6: `esc_char` followed by a byte that matches no enabled rule and is not a separator raises `err` for one cycle. Both bytes then pass through unchanged as payload, and `in_ready` is 0 in the cycle after the second byte is accepted.
- R7: With `rule_en` all zero, `esc_char` is ordinary payload.
- R8: The payload byte that makes the frame's byte count exceed `len_limit` carries `out_eof`=1. The next payload byte starts a new frame. With `len_limit`=0, every byte is a frame of its own.
- R9: A separator accepted while an escape is pending ends the frame, discards the escape-lead byte and raises `err` for one cycle. It does not raise `rx_start`.
- R10: With `sep_en`=0, `sep_char` is ordinary payload, and frames end only on the length limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Input byte accepted when high with in_valid |
| in_data | input | 8 | Received byte |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Downstream takes the beat |
| out_data | output | 8 | Decoded payload byte |
| out_sof | output | 1 | First byte of a frame |
| out_eof | output | 1 | Last byte of a frame |
| sep_en | input | 1 | Separator framing enable |
| sep_char | input | 8 | Separator byte value |
| esc_char | input | 8 | Escape-lead byte value |
| rule_en | input | NRULE | Per-rule enable |
| rule_code | input | NRULE*8 | Code byte of rule i at bits 8i+7:8i |
| rule_val | input | NRULE*8 | Result byte of rule i at bits 8i+7:8i |
| len_limit | input | LEN_W | Payload length threshold |
| rx_start | output | 1 | One-cycle pulse: separator with no frame open |
| err | output | 1 | One-cycle pulse: malformed or cut escape |

## Verification
The bench builds the decoder with the defaults: four rules and a 13-bit length limit. With four rules, it can disable one rule alone, give two rules the same code to exercise priority, and clear all enables. It runs the limit at 0, 2, 3 and 4, so frames close by length within a few bytes. It also runs the limit at 8191, so only separators end frames. A long random run mixes separators, escape leads and code bytes under random `out_ready`, so spills, stalls and limit-ended frames overlap.

// File: rtl/sfd_pkg.sv
`timescale 1ns/1ps
package sfd_pkg;
  localparam int BYTE_W = 8;

  typedef struct packed {
    logic              sof;
    logic              eof;
    logic [BYTE_W-1:0] data;
  } sfd_beat_t;
endpackage

// File: rtl/sfd_rule_match.sv
`timescale 1ns/1ps
module sfd_rule_match #(
  parameter int NRULE = 4
) (
  input  logic [7:0]         code_in,
  input  logic [NRULE-1:0]   rule_en,
  input  logic [NRULE*8-1:0] rule_code,
  input  logic [NRULE*8-1:0] rule_val,
  output logic               hit,
  output logic [7:0]         hit_val
);
  logic [NRULE-1:0] match;

  for (genvar gi = 0; gi < NRULE; gi++) begin : g_rule
    assign match[gi] = rule_en[gi] && (code_in == rule_code[gi*8 +: 8]);
  end

  // lowest index takes priority: scan downward so it is written last
  always_comb begin
    hit_val = 8'h00;
    for (int i = NRULE - 1; i >= 0; i--) begin
      if (match[i]) hit_val = rule_val[i*8 +: 8];
    end
  end

  assign hit = |match;
endmodule

// File: rtl/sfd_len_track.sv
`timescale 1ns/1ps
module sfd_len_track #(
  parameter int LEN_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             clear,
  input  logic [LEN_W-1:0] limit,
  output logic             first,
  output logic             last
);
  logic [LEN_W-1:0] cnt_q;

  assign first = (cnt_q == '0);
  // the byte being pushed is number cnt_q+1; it is last when that exceeds limit
  assign last  = (cnt_q >= limit);

  always_ff @(posedge clk) begin
    if (!rst_n)     cnt_q <= '0;
    else if (clear) cnt_q <= '0;
    else if (push)  cnt_q <= last ? '0 : cnt_q + LEN_W'(1);
  end
endmodule

// File: rtl/sfd_out_reg.sv
`timescale 1ns/1ps
module sfd_out_reg
  import sfd_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      load,
  input  sfd_beat_t beat_in,
  input  logic      out_ready,
  output logic      out_valid,
  output sfd_beat_t beat_out,
  output logic      slot_free
);
  assign slot_free = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      beat_out  <= '0;
    end else if (load) begin
      out_valid <= 1'b1;
      beat_out  <= beat_in;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // R2
  hold_on_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(beat_out)));

  // R2
  load_into_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load && out_valid) |-> out_ready);
endmodule

// File: rtl/sfd_decoder.sv
`timescale 1ns/1ps
module sfd_decoder
  import sfd_pkg::*;
#(
  parameter int NRULE = 4,
  parameter int LEN_W = 13
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [7:0]         in_data,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [7:0]         out_data,
  output logic               out_sof,
  output logic               out_eof,
  input  logic               sep_en,
  input  logic [7:0]         sep_char,
  input  logic [7:0]         esc_char,
  input  logic [NRULE-1:0]   rule_en,
  input  logic [NRULE*8-1:0] rule_code,
  input  logic [NRULE*8-1:0] rule_val,
  input  logic [LEN_W-1:0]   len_limit,
  output logic               rx_start,
  output logic               err
);
  logic       slot_free;
  logic       spill_v, pend_q;
  logic [7:0] spill_q;
  logic       hold_v, hold_sof, hold_eof;
  logic [7:0] hold_q;
  logic       first, last;
  logic       hit;
  logic [7:0] hit_val;
  logic       accept, is_sep, is_lead;
  logic       push_v, flush_v, pend_d, spill_set, err_d, rxs_d;
  logic [7:0] push_byte;
  logic       emit;
  sfd_beat_t  beat_in, beat_out;

  assign in_ready = slot_free && !spill_v;
  assign accept   = in_valid && in_ready;
  assign is_sep   = sep_en && (in_data == sep_char);
  assign is_lead  = (|rule_en) && (in_data == esc_char);

  sfd_rule_match #(.NRULE(NRULE)) u_match (
    .code_in  (in_data),
    .rule_en  (rule_en),
    .rule_code(rule_code),
    .rule_val (rule_val),
    .hit      (hit),
    .hit_val  (hit_val)
  );

  // per-cycle decision: at most one payload push or one frame flush
  always_comb begin
    push_v    = 1'b0;
    push_byte = in_data;
    flush_v   = 1'b0;
    pend_d    = pend_q;
    spill_set = 1'b0;
    err_d     = 1'b0;
    rxs_d     = 1'b0;
    if (spill_v) begin
      if (slot_free) begin
        push_v    = 1'b1;
        push_byte = spill_q;
      end
    end else if (accept) begin
      if (!pend_q) begin
        if (is_sep) begin
          flush_v = 1'b1;
          rxs_d   = first;
        end else if (is_lead) begin
          pend_d = 1'b1;
        end else begin
          push_v = 1'b1;
        end
      end else begin
        pend_d = 1'b0;
        if (is_sep) begin
          flush_v = 1'b1;
          err_d   = 1'b1;
        end else if (hit) begin
          push_v    = 1'b1;
          push_byte = hit_val;
        end else begin
          push_v    = 1'b1;
          push_byte = esc_char;
          spill_set = 1'b1;
          err_d     = 1'b1;
        end
      end
    end
  end

  sfd_len_track #(.LEN_W(LEN_W)) u_len (
    .clk  (clk),
    .rst_n(rst_n),
    .push (push_v),
    .clear(flush_v),
    .limit(len_limit),
    .first(first),
    .last (last)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q   <= 1'b0;
      spill_v  <= 1'b0;
      spill_q  <= 8'h00;
      hold_v   <= 1'b0;
      hold_q   <= 8'h00;
      hold_sof <= 1'b0;
      hold_eof <= 1'b0;
      err      <= 1'b0;
      rx_start <= 1'b0;
    end else begin
      pend_q   <= pend_d;
      err      <= err_d;
      rx_start <= rxs_d;
      if (spill_set) begin
        spill_v <= 1'b1;
        spill_q <= in_data;
      end else if (spill_v && slot_free) begin
        spill_v <= 1'b0;
      end
      if (push_v) begin
        hold_v   <= 1'b1;
        hold_q   <= push_byte;
        hold_sof <= first;
        hold_eof <= last;
      end else if (flush_v) begin
        hold_v <= 1'b0;
      end
    end
  end

  assign emit         = (push_v || flush_v) && hold_v;
  assign beat_in.sof  = hold_sof;
  assign beat_in.eof  = hold_eof || flush_v;
  assign beat_in.data = hold_q;

  sfd_out_reg u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (emit),
    .beat_in  (beat_in),
    .out_ready(out_ready),
    .out_valid(out_valid),
    .beat_out (beat_out),
    .slot_free(slot_free)
  );

  assign out_data = beat_out.data;
  assign out_sof  = beat_out.sof;
  assign out_eof  = beat_out.eof;

  // frame tracking seen from the output port, used by the checks below
  logic open_q;
  always_ff @(posedge clk) begin
    if (!rst_n)                      open_q <= 1'b0;
    else if (out_valid && out_ready) open_q <= !out_eof;
  end

  // R3
  frame_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_sof == !open_q));

  // R9
  pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(err && rx_start));

  // R4
  rx_start_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_start |-> $past(in_valid && in_ready));
endmodule

// File: tb/sfd_decoder_bench.sv
`timescale 1ns/1ps
module sfd_decoder_bench;
  localparam int NR = 4;
  localparam int LW = 13;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic            in_valid = 1'b0, in_ready;
  logic [7:0]      in_data = 8'h00;
  logic            out_valid, out_sof, out_eof, rx_start, err;
  logic            out_ready = 1'b1;
  logic [7:0]      out_data;
  logic            c_sep_en = 1'b1;
  logic [7:0]      c_sep = 8'hC0, c_esc = 8'hDB;
  logic [NR-1:0]   c_en = 4'hF;
  logic [NR*8-1:0] c_code = 32'hDFDEDDDC;
  logic [NR*8-1:0] c_val  = 32'h1311DBC0;
  logic [LW-1:0]   c_lim  = 13'd8191;

  sfd_decoder #(.NRULE(NR), .LEN_W(LW)) u_sfd_decoder (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_sof(out_sof), .out_eof(out_eof),
    .sep_en(c_sep_en), .sep_char(c_sep), .esc_char(c_esc), .rule_en(c_en),
    .rule_code(c_code), .rule_val(c_val), .len_limit(c_lim),
    .rx_start(rx_start), .err(err)
  );

  int total = 0, bad = 0;
  string cur_tag = "R3";

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // behavioural reference model
  logic [9:0] q[$];
  bit   m_hv = 0, m_hsof = 0, m_heof = 0, m_pend = 0;
  logic [7:0] m_hold = 0;
  int   m_cnt = 0;
  bit   exp_err = 0, exp_rx = 0, exp_stall = 0;

  task automatic m_push(input logic [7:0] b);
    if (m_hv) q.push_back({m_hsof, m_heof, m_hold});
    m_hold = b;
    m_hsof = (m_cnt == 0);
    m_cnt++;
    if (m_cnt > int'(c_lim)) begin m_heof = 1; m_cnt = 0; end
    else m_heof = 0;
    m_hv = 1;
  endtask

  task automatic m_sep(input bit with_err);
    if (m_hv) q.push_back({m_hsof, 1'b1, m_hold});
    m_hv = 0;
    exp_rx  = !with_err && (m_cnt == 0);
    exp_err = with_err;
    m_cnt = 0;
  endtask

  task automatic m_accept(input logic [7:0] b);
    bit is_sep, found;
    logic [7:0] v;
    is_sep = c_sep_en && (b == c_sep);
    if (!m_pend) begin
      if (is_sep) m_sep(0);
      else if ((c_en != 0) && b == c_esc) m_pend = 1;
      else m_push(b);
    end else begin
      m_pend = 0;
      if (is_sep) m_sep(1);
      else begin
        found = 0; v = 0;
        for (int i = 0; i < NR; i++)
          if (!found && c_en[i] && c_code[i*8 +: 8] == b) begin found = 1; v = c_val[i*8 +: 8]; end
        if (found) m_push(v);
        else begin
          m_push(c_esc); m_push(b);
          exp_err = 1; exp_stall = 1;
        end
      end
    end
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk);
    in_valid = 1'b1; in_data = b;
    while (!in_ready) @(negedge clk);
    m_accept(b);
    @(posedge clk);
    #1 in_valid = 1'b0;
  endtask

  bit rnd_mode = 0;
  always @(posedge clk) begin
    #1 out_ready = rnd_mode ? ($urandom % 3 != 0) : 1'b1;
  end

  // per-clock comparison against the model
  bit mon_on = 0, prev_stall = 0;
  logic [9:0] prev_beat;
  always @(posedge clk) begin
    #2;
    if (mon_on) begin
      chk(err == exp_err, "R6 or R9 err pulse", err, exp_err);
      chk(rx_start == exp_rx, "R4 rx_start pulse", rx_start, exp_rx);
      exp_err = 0; exp_rx = 0;
      if (exp_stall) begin
        chk(in_ready == 1'b0, "R6 spill stall", in_ready, 0);
        exp_stall = 0;
      end
      if (prev_stall)
        chk(out_valid && {out_sof, out_eof, out_data} == prev_beat, "R2 stable under stall",
            {out_valid, out_sof, out_eof, out_data}, {1'b1, prev_beat});
      prev_stall = out_valid && !out_ready;
      prev_beat  = {out_sof, out_eof, out_data};
      if (prev_stall) chk(!in_ready, "R2 in_ready low", in_ready, 0);
      if (out_valid && out_ready) begin
        if (q.size() == 0) chk(0, {cur_tag, " unexpected beat"}, {out_sof, out_eof, out_data}, 0);
        else begin
          logic [9:0] e;
          e = q.pop_front();
          chk({out_sof, out_eof, out_data} == e, {cur_tag, " beat"}, {out_sof, out_eof, out_data}, e);
        end
      end
    end
  end

  task automatic drain(input string tag);
    repeat (20) @(posedge clk);
    chk(q.size() == 0, {tag, " all beats seen"}, q.size(), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(posedge clk); #2;
    // R1
    chk(out_valid == 0, "R1 out_valid", out_valid, 0);
    chk(err == 0, "R1 err", err, 0);
    chk(rx_start == 0, "R1 rx_start", rx_start, 0);
    chk(in_ready == 1, "R1 in_ready", in_ready, 1);
    mon_on = 1;

    cur_tag = "R3";
    send(8'hC0); send(8'h01); send(8'h02); send(8'h03); send(8'hC0);
    drain("R3");

    cur_tag = "R4";
    send(8'hC0); send(8'hC0); send(8'hC0); send(8'h05); send(8'hC0); send(8'hC0);
    drain("R4");

    cur_tag = "R5";
    send(8'hC0); send(8'hDB); send(8'hDC); send(8'h05); send(8'hDB); send(8'hDD);
    send(8'hDB); send(8'hDE); send(8'hDB); send(8'hDF); send(8'hC0);
    drain("R5");
    @(negedge clk) c_code[23:16] = 8'hDC; c_val[23:16] = 8'h77;
    send(8'hDB); send(8'hDC); send(8'hC0);
    drain("R5 priority");
    @(negedge clk) c_code[23:16] = 8'hDE; c_val[23:16] = 8'h11;

    cur_tag = "R6";
    @(negedge clk) c_en = 4'b1101;
    send(8'hC0); send(8'h01); send(8'hDB); send(8'hDD); send(8'h02); send(8'hC0);
    drain("R6");

    cur_tag = "R7";
    @(negedge clk) c_en = 4'b0000;
    send(8'hDB); send(8'hDC); send(8'hC0);
    drain("R7");

    cur_tag = "R8";
    @(negedge clk) begin c_en = 4'hF; c_lim = 13'd3; end
    send(8'hC0);
    for (int i = 1; i <= 7; i++) send(8'(i));
    send(8'hC0);
    drain("R8");
    @(negedge clk) c_lim = 13'd0;
    send(8'h0A); send(8'h0B); send(8'hC0);
    drain("R8 zero limit");

    cur_tag = "R9";
    @(negedge clk) c_lim = 13'd8191;
    send(8'h01); send(8'h02); send(8'hDB); send(8'hC0); send(8'h03); send(8'hC0);
    drain("R9");

    cur_tag = "R10";
    @(negedge clk) begin c_sep_en = 1'b0; c_lim = 13'd2; end
    send(8'h01); send(8'hC0); send(8'h02); send(8'h03);
    @(negedge clk) c_sep_en = 1'b1;
    send(8'hC0);
    drain("R10");

    cur_tag = "R2";
    @(negedge clk) begin c_lim = 13'd4; c_en = 4'b1011; end
    rnd_mode = 1;
    for (int n = 0; n < 3000; n++) begin
      logic [7:0] b;
      case ($urandom % 8)
        0: b = 8'hC0;
        1, 2: b = 8'hDB;
        3: b = 8'hDC;
        4: b = 8'hDD;
        5: b = 8'hDF;
        default: b = 8'($urandom);
      endcase
      send(b);
    end
    send(8'hC0); send(8'hC0);
    rnd_mode = 0;
    drain("R2");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule